// File: doc/BRIEF.md
# Set-Associative Cache with Selectable Write Policy

This block is a small set-associative cache that sits between a CPU-side request port and a lower-level memory. Each byte address is split into a tag, a set index and a block offset. The set index picks one set, and every way of that set compares its stored tag with the request tag in the same cycle. A hit answers in the cycle of the request. A miss holds the request, fetches the whole block from lower memory one 64-bit word per cycle, and then serves the held request from the refilled line.

A build parameter selects the write policy. In write-through mode, every write goes to lower memory in the cycle it is accepted, and a write miss does not allocate a line. In write-back mode, writes stay in the cache and mark the line dirty. A write miss allocates the block. A dirty line is copied out only when it is chosen as a victim. The victim way is supplied from outside the block by a replacement selector.

Top module: `setassoc_cache`

## Requirements
- R1: With the default 16-byte blocks and 4 sets, address bits [3:0] are the block offset, bits [5:4] are the set index and bits [31:6] are the tag. Bit 3 selects the 64-bit word within the block, and bits [2:0] are ignored.
- R2: All ways of the selected set compare tags in parallel, and at most one way can hit. A read hit raises `cpu_ready` with valid `cpu_rdata` in the same cycle as the request and causes no lower-memory traffic.
- R3: Every line is invalid after reset, so the first access to any block misses. A line that is being refilled cannot hit.
- R4: A miss issues a single-cycle `mem_rd` with the block-aligned address. It stores the returned words in order, marks the line valid and then completes the held request.
- R5: A write changes only the bytes whose `cpu_be` bit is set (bit b covers data bits 8b+7:8b). The cache array is modified only when the tag check reports a hit.
- R6: In write-through mode, each write is accepted in the cycle of its request and drives `mem_wr` with the same address, byte enables and data. A write miss does not allocate the block.
- R7: In write-back mode, a write hit produces no lower-memory write and marks the line dirty. A write miss first fetches the block and then merges the write into it.
- R8: On a write-back miss whose victim line is valid and dirty, all words of the victim are written to lower memory before the fetch. A clean victim is dropped with no write.
- R9: The victim way is the value of `victim_way` in the cycle the miss is detected. The other ways of the set keep their contents.
- R10: The request is held while `cpu_ready` is low. A miss never raises `cpu_ready` in the request's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 8 | Byte enables of the write |
| cpu_wdata | input | 64 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 64 | Read data, valid with `cpu_ready` on a read |
| victim_way | input | 1 | Way to replace on a miss |
| mem_rd | output | 1 | Block fetch request (one cycle) |
| mem_wr | output | 1 | One-word write to lower memory |
| mem_addr | output | 32 | Lower-memory byte address |
| mem_be | output | 8 | Byte enables of the lower-memory write |
| mem_wdata | output | 64 | Lower-memory write data |
| mem_rvalid | input | 1 | Returned fetch word valid |
| mem_rdata | input | 64 | Returned fetch word |

## Verification
A hit, and a write-through write, are due in the request's own cycle: `cpu_ready`, `cpu_rdata` and the forwarded `mem_wr` are all combinational from the request. A miss raises `mem_rd` one cycle after detection, or one cycle after the last eviction word when a dirty victim is copied out first. The words then arrive after the memory latency, and the request completes in the cycle after the last word. Inputs change two time units after a rising edge, and all sampling happens on the falling edge. The driver records whether ready came on the first falling edge, which separates hits from misses. It also counts `mem_rd` and `mem_wr` pulses at the falling edge, and it compares the words in lower memory only after the edge that commits them.

// File: rtl/setassoc_cache.sv
module setassoc_cache #(
  parameter int ADDR_W      = 32,
  parameter int WAYS        = 2,
  parameter int SETS        = 4,
  parameter int BLOCK_BYTES = 16,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [7:0]                cpu_be,
  input  logic [63:0]               cpu_wdata,
  output logic                      cpu_ready,
  output logic [63:0]               cpu_rdata,
  input  logic [$clog2(WAYS)-1:0]   victim_way,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [7:0]                mem_be,
  output logic [63:0]               mem_wdata,
  input  logic                      mem_rvalid,
  input  logic [63:0]               mem_rdata
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WPB    = BLOCK_BYTES / 8;
  localparam int WSEL_W = $clog2(WPB);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINES  = SETS * WAYS;
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WPB - 1);

  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FETCH, S_FILL} state_t;
  state_t st;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [63:0]       dat_q [LINES*WPB];
  logic [LINES-1:0]  val_q, dty_q;
  logic [WAY_W-1:0]  vway, hway;
  logic [WSEL_W-1:0] cnt;
  logic [WAYS-1:0]   way_hit;

  wire [TAG_W-1:0]  a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  a_set  = cpu_addr[OFF_W +: IDX_W];
  wire [WSEL_W-1:0] a_word = cpu_addr[3 +: WSEL_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = val_q[{a_set, WAY_W'(w)}] && (tag_q[{a_set, WAY_W'(w)}] == a_tag);
  end

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hway = WAY_W'(w);
  end

  wire hit   = |way_hit;
  wire [IDX_W+WAY_W-1:0] hline = {a_set, hway};
  wire [IDX_W+WAY_W-1:0] vline = {a_set, vway};
  wire [IDX_W+WAY_W-1:0] nline = {a_set, victim_way};
  wire look  = (st == S_LOOK) && cpu_req;
  wire wt_wr = !WRITE_BACK && look && cpu_we;
  wire hit_wr    = look && hit && cpu_we;
  wire fill_we   = (st == S_FILL) && mem_rvalid;
  wire fill_last = fill_we && (cnt == LAST);

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] be);
    merge = old;
    for (int b = 0; b < 8; b++)
      if (be[b]) merge[8*b +: 8] = nw[8*b +: 8];
  endfunction

  assign cpu_ready = look && (hit || wt_wr);
  assign cpu_rdata = dat_q[{hline, a_word}];
  assign mem_rd    = (st == S_FETCH);
  assign mem_wr    = wt_wr || (st == S_EVICT);
  assign mem_be    = wt_wr ? cpu_be : 8'hFF;
  assign mem_wdata = wt_wr ? cpu_wdata : dat_q[{vline, cnt}];
  assign mem_addr  = (st == S_EVICT) ? {tag_q[vline], a_set, cnt, 3'b000} :
                     wt_wr           ? {cpu_addr[ADDR_W-1:3], 3'b000} :
                                       {a_tag, a_set, {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_LOOK;
      val_q <= '0;
      dty_q <= '0;
      cnt   <= '0;
      vway  <= '0;
    end else begin
      case (st)
        S_LOOK:
          if (look && !hit && !wt_wr) begin
            vway <= victim_way;
            cnt  <= '0;
            st   <= (WRITE_BACK && val_q[nline] && dty_q[nline]) ? S_EVICT : S_FETCH;
          end else if (hit_wr && WRITE_BACK) begin
            dty_q[hline] <= 1'b1;
          end
        S_EVICT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FETCH;
        end
        S_FETCH: begin
          val_q[vline] <= 1'b0;
          st           <= S_FILL;
        end
        default:
          if (fill_we) begin
            cnt <= cnt + 1'b1;
            if (fill_last) begin
              val_q[vline] <= 1'b1;
              dty_q[vline] <= 1'b0;
              st           <= S_LOOK;
            end
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hit_wr) dat_q[{hline, a_word}] <= merge(dat_q[{hline, a_word}], cpu_wdata, cpu_be);
    if (fill_we) dat_q[{vline, cnt}] <= mem_rdata;
    if (fill_last) tag_q[vline] <= a_tag;
  end

  assert_one_way_hit_R2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(way_hit));
  assert_no_hit_in_fill_R3: assert property (@(posedge clk) disable iff (!rst_n) (st == S_FILL) |-> !cpu_ready);
  assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd && !cpu_ready);
  assert_wt_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && cpu_ready && cpu_we) |-> (mem_wr && mem_be == cpu_be && mem_wdata == cpu_wdata));
  assert_wb_local_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && cpu_ready && cpu_we) |-> !mem_wr);
  assert_rd_wr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n) (cpu_req && !cpu_ready) |=> cpu_req);
endmodule

// File: tb/test_setassoc_cache.sv
module lowmem_model #(parameter int LAT = 3, parameter int WPB = 2) (
  input  logic        clk,
  input  logic        rd,
  input  logic        wr,
  input  logic [31:0] addr,
  input  logic [7:0]  be,
  input  logic [63:0] wd,
  output logic        rvalid,
  output logic [63:0] rdata
);
  logic [63:0] mem [256];
  logic [7:0] base;
  int dly, k;
  logic busy = 1'b0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {32'hC0DE0000 | i, ~i};
    rvalid = 1'b0;
    rdata  = '0;
  end
  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (wr)
      for (int b = 0; b < 8; b++)
        if (be[b]) mem[addr[10:3]][8*b +: 8] <= wd[8*b +: 8];
    if (rd) begin
      base <= addr[10:3]; dly <= LAT; k <= 0; busy <= 1'b1;
    end else if (busy) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        rvalid <= 1'b1;
        rdata  <= mem[base + 8'(k)];
        if (k == WPB - 1) busy <= 1'b0;
        k <= k + 1;
      end
    end
  end
endmodule

module test_setassoc_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic c_we = 1'b0; logic [31:0] c_addr = '0; logic [7:0] c_be = '0; logic [63:0] c_wd = '0;
  logic req_wb = 1'b0, req_wt = 1'b0, vic_wb = 1'b0, vic_wt = 1'b0;
  logic rdy_wb, rdy_wt, mrd_wb, mrd_wt, mwr_wb, mwr_wt, rv_wb, rv_wt;
  logic [63:0] rd_wb, rd_wt, mwd_wb, mwd_wt, mrdat_wb, mrdat_wt;
  logic [31:0] ma_wb, ma_wt; logic [7:0] mbe_wb, mbe_wt;

  setassoc_cache #(.WRITE_BACK(1'b1)) i_setassoc_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_wb), .cpu_we(c_we), .cpu_addr(c_addr), .cpu_be(c_be),
    .cpu_wdata(c_wd), .cpu_ready(rdy_wb), .cpu_rdata(rd_wb), .victim_way(vic_wb), .mem_rd(mrd_wb),
    .mem_wr(mwr_wb), .mem_addr(ma_wb), .mem_be(mbe_wb), .mem_wdata(mwd_wb), .mem_rvalid(rv_wb),
    .mem_rdata(mrdat_wb));
  lowmem_model i_mem_wb (.clk(clk), .rd(mrd_wb), .wr(mwr_wb), .addr(ma_wb), .be(mbe_wb), .wd(mwd_wb),
    .rvalid(rv_wb), .rdata(mrdat_wb));

  setassoc_cache #(.WRITE_BACK(1'b0)) i_setassoc_cache_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_wt), .cpu_we(c_we), .cpu_addr(c_addr), .cpu_be(c_be),
    .cpu_wdata(c_wd), .cpu_ready(rdy_wt), .cpu_rdata(rd_wt), .victim_way(vic_wt), .mem_rd(mrd_wt),
    .mem_wr(mwr_wt), .mem_addr(ma_wt), .mem_be(mbe_wt), .mem_wdata(mwd_wt), .mem_rvalid(rv_wt),
    .mem_rdata(mrdat_wt));
  lowmem_model i_mem_wt (.clk(clk), .rd(mrd_wt), .wr(mwr_wt), .addr(ma_wt), .be(mbe_wt), .wd(mwd_wt),
    .rvalid(rv_wt), .rdata(mrdat_wt));

  int nchk = 0, nfail = 0;
  int nrd_wb = 0, nwr_wb = 0, nrd_wt = 0, nwr_wt = 0;
  logic [63:0] ref_wb [256], ref_wt [256];
  logic [63:0] q_wb [$], q_wt [$];
  int qr_wb [$], qr_wt [$];

  task automatic check(input int r, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mrd_wb) nrd_wb++;
    if (mwr_wb) nwr_wb++;
    if (mrd_wt) nrd_wt++;
    if (mwr_wt) nwr_wt++;
  end

  always @(negedge clk) begin
    if (req_wb && rdy_wb && !c_we) begin
      if (q_wb.size() == 0) check(2, 1'b0, rd_wb, '0);
      else begin
        logic [63:0] e; int r;
        e = q_wb.pop_front(); r = qr_wb.pop_front();
        check(r, rd_wb === e, rd_wb, e);
      end
    end
    if (req_wt && rdy_wt && !c_we) begin
      if (q_wt.size() == 0) check(2, 1'b0, rd_wt, '0);
      else begin
        logic [63:0] e; int r;
        e = q_wt.pop_front(); r = qr_wt.pop_front();
        check(r, rd_wt === e, rd_wt, e);
      end
    end
  end

  task automatic op(input bit sel, input bit we, input logic [31:0] a, input logic [7:0] be,
                    input logic [63:0] d, input bit miss, input int r);
    int n;
    logic [7:0] wi;
    wi = a[10:3];
    if (we) begin
      for (int b = 0; b < 8; b++)
        if (be[b]) begin
          if (sel) ref_wt[wi][8*b +: 8] = d[8*b +: 8];
          else     ref_wb[wi][8*b +: 8] = d[8*b +: 8];
        end
    end else if (sel) begin
      q_wt.push_back(ref_wt[wi]); qr_wt.push_back(r);
    end else begin
      q_wb.push_back(ref_wb[wi]); qr_wb.push_back(r);
    end
    @(posedge clk); #2;
    c_we = we; c_addr = a; c_be = be; c_wd = d;
    if (sel) req_wt = 1'b1; else req_wb = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (sel ? rdy_wt : rdy_wb) break;
      n++;
      if (n > 100) break;
    end
    check(r, (n == 0) == !miss, 64'(n), 64'(!miss));
    if (miss) check(10, n > 0, 64'(n), 64'd1); // R10 miss holds the request
    @(posedge clk); #2;
    req_wb = 1'b0; req_wt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int b_rd, b_wr;
    for (int i = 0; i < 256; i++) begin
      ref_wb[i] = {32'hC0DE0000 | i, ~i};
      ref_wt[i] = {32'hC0DE0000 | i, ~i};
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(3, !rdy_wb && !mrd_wb && !mwr_wb, {61'd0, rdy_wb, mrd_wb, mwr_wb}, '0); // R3 reset state

    // write-back instance
    b_rd = nrd_wb;
    op(0, 0, 32'h000, 8'h00, '0, 1, 3);                  // R3 cold miss
    check(4, nrd_wb == b_rd + 1, 64'(nrd_wb), 64'(b_rd + 1)); // R4 one fetch
    op(0, 0, 32'h00C, 8'h00, '0, 0, 1);                  // R1 word 1, low bits ignored
    vic_wb = 1'b1;
    op(0, 0, 32'h040, 8'h00, '0, 1, 9);                  // R9 fill way 1
    vic_wb = 1'b0;
    b_rd = nrd_wb;
    op(0, 0, 32'h000, 8'h00, '0, 0, 2);                  // R2 both ways hit
    op(0, 0, 32'h048, 8'h00, '0, 0, 2);
    check(2, nrd_wb == b_rd, 64'(nrd_wb), 64'(b_rd));
    b_wr = nwr_wb;
    op(0, 1, 32'h000, 8'h0F, 64'h1122334455667788, 0, 5); // R5 partial write
    check(7, nwr_wb == b_wr, 64'(nwr_wb), 64'(b_wr));     // R7 no memory write
    op(0, 0, 32'h000, 8'h00, '0, 0, 5);
    b_rd = nrd_wb; b_wr = nwr_wb;
    op(0, 0, 32'h080, 8'h00, '0, 1, 8);                  // R8 dirty eviction of way 0
    check(8, nwr_wb == b_wr + 2, 64'(nwr_wb), 64'(b_wr + 2));
    check(8, i_mem_wb.mem[0] == ref_wb[0], i_mem_wb.mem[0], ref_wb[0]);
    check(4, nrd_wb == b_rd + 1, 64'(nrd_wb), 64'(b_rd + 1));
    vic_wb = 1'b1;
    b_wr = nwr_wb;
    op(0, 0, 32'h000, 8'h00, '0, 1, 8);                  // R8 clean victim dropped
    check(8, nwr_wb == b_wr, 64'(nwr_wb), 64'(b_wr));
    op(0, 0, 32'h080, 8'h00, '0, 0, 9);                  // R9 way 0 kept
    op(0, 0, 32'h040, 8'h00, '0, 1, 9);                  // R9 replaced earlier
    vic_wb = 1'b0;
    b_rd = nrd_wb;
    op(0, 1, 32'h108, 8'hF0, 64'hDEADBEEF_00000000, 1, 7); // R7 write-allocate
    check(7, nrd_wb == b_rd + 1, 64'(nrd_wb), 64'(b_rd + 1));
    op(0, 0, 32'h108, 8'h00, '0, 0, 7);
    check(7, i_mem_wb.mem[8'h21] == {32'hC0DE0021, ~32'h21}, i_mem_wb.mem[8'h21], {32'hC0DE0021, ~32'h21});

    // write-through instance
    op(1, 0, 32'h200, 8'h00, '0, 1, 4);                  // R4 fill
    b_wr = nwr_wt;
    op(1, 1, 32'h200, 8'h01, 64'h00000000_000000AB, 0, 6); // R6 forwarded write hit
    check(6, nwr_wt == b_wr + 1, 64'(nwr_wt), 64'(b_wr + 1));
    check(6, i_mem_wt.mem[8'h40] == ref_wt[8'h40], i_mem_wt.mem[8'h40], ref_wt[8'h40]);
    op(1, 0, 32'h200, 8'h00, '0, 0, 6);                  // R6 cache updated too
    b_rd = nrd_wt; b_wr = nwr_wt;
    op(1, 1, 32'h318, 8'hFF, 64'h0123456789ABCDEF, 0, 6); // R6 write miss, no allocate
    check(6, nrd_wt == b_rd && nwr_wt == b_wr + 1, 64'(nrd_wt), 64'(b_rd));
    op(1, 0, 32'h318, 8'h00, '0, 1, 6);                  // R6 still a miss

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule